// File: doc/BRIEF.md
# Three-Channel IF Phase and Magnitude Detector

This block turns three streams of undersampled intermediate-frequency samples into magnitude and phase words, one pair per channel. The channels carry forward power, reflected power and cavity output. A 50 MHz IF sampled at 40 MSPS folds down to a 10 MHz alias, so every alias period spans exactly four samples. Taken in order, these four samples give the in-phase value, the quadrature value, the negated in-phase value and the negated quadrature value. The block restores the signs and holds one in-phase/quadrature pair per channel for each conversion.

Every channel has its own iterative vectoring-mode coordinate-rotation datapath. All three datapaths run from one free-running 4-bit step counter, so a 16-cycle frame holds one coarse ±90° rotation followed by fifteen micro-rotations. At the start of each new conversion, the finished results of all three channels are copied into the output registers together, and a one-cycle strobe marks the update. A reader that samples the three channels at the strobe therefore gets values from one common sample instant.

The phase is a signed 16-bit binary angle in which 32768 stands for 180°. The magnitude keeps the uncompensated rotation gain of about 1.6468.

Top module: `if_phase_detector`

## Requirements
- R1: While reset is held, and after its release until the first conversion is published, every magnitude and phase output reads 0 and the valid strobe stays low.
- R2: Cycles are numbered from 0 at the first clock after reset release. Within each frame of 16 cycles, the quadrature value Q is the sample of cycle 13 and the in-phase value I is the negated sample of cycle 14. Samples taken in any other cycle of the frame have no effect on the result.
- R3: Each magnitude output is an 18-bit unsigned value equal to 1.6468·sqrt(I²+Q²), within a tolerance of a few tens of LSB.
- R4: Each phase output equals atan2(Q, I) as a signed 16-bit binary angle (16384 = 90°, ±32768 = ±180°). This holds in all four quadrants.
- R5: On-axis vectors give the axis angles: Q=0 with I>0 gives about 0, I=0 with Q>0 gives about 16384, I=0 with Q<0 gives about -16384, and Q=0 with I<0 gives about ±32768.
- R6: All three channels publish on the same strobe, and every channel's values come from the same frame.
- R7: The valid strobe is high for exactly one cycle, at cycle 0 of a frame, once every 16 cycles. The outputs do not change while the strobe is low.
- R8: Full-scale samples, including -32768 in either sample slot (which yields I = +32768), convert without wrap-around. The magnitude can reach about 76,300.
- R9: The result of frame k is published with the strobe in cycle 16·(k+2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fwd_sample_i | input | 16 | Signed forward-power IF sample |
| refl_sample_i | input | 16 | Signed reflected-power IF sample |
| cav_sample_i | input | 16 | Signed cavity-output IF sample |
| fwd_mag_o | output | 18 | Forward-power magnitude |
| fwd_phase_o | output | 16 | Forward-power phase, binary angle |
| refl_mag_o | output | 18 | Reflected-power magnitude |
| refl_phase_o | output | 16 | Reflected-power phase, binary angle |
| cav_mag_o | output | 18 | Cavity magnitude |
| cav_phase_o | output | 16 | Cavity phase, binary angle |
| result_valid_o | output | 1 | One-cycle strobe, high when all outputs have just updated |

## Verification
The assertions check the following on every cycle:
- the strobe lasts one cycle and falls on frame cycle 0;
- the outputs hold while the strobe is low;
- the working x value is non-negative after the coarse rotation and never decreases during the micro-rotations;
- every published magnitude is non-negative.

Only the bench's scenarios can show that the numbers are right. These scenarios cover the magnitude and angle in each quadrant and on the axes, the full-scale corner, the choice of sample slots against scrambled samples in the unused cycles, and the two-frame latency from input to result.

// File: rtl/ifpd_pkg.sv
`timescale 1ns/1ps
package ifpd_pkg;

    localparam int NUM_CH = 3;
    localparam int ANG_W  = 16;
    localparam logic [ANG_W-1:0] QUARTER_TURN = 16'h4000;

    // Binary angle of atan(2^-step) with 65536 counts per turn
    function automatic logic [ANG_W-1:0] micro_angle(input logic [3:0] step);
        logic [ANG_W-1:0] a;
        case (step)
            4'd0:    a = 16'd8192;
            4'd1:    a = 16'd4836;
            4'd2:    a = 16'd2555;
            4'd3:    a = 16'd1297;
            4'd4:    a = 16'd651;
            4'd5:    a = 16'd326;
            4'd6:    a = 16'd163;
            4'd7:    a = 16'd81;
            4'd8:    a = 16'd41;
            4'd9:    a = 16'd20;
            4'd10:   a = 16'd10;
            4'd11:   a = 16'd5;
            4'd12:   a = 16'd3;
            4'd13:   a = 16'd1;
            4'd14:   a = 16'd1;
            default: a = 16'd0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/ifpd_sequencer.sv
`timescale 1ns/1ps
module ifpd_sequencer #(
    parameter int CTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CTR_W-1:0] step_o,
    output logic [1:0]       phase_o,
    output logic             load_o,
    output logic             publish_o,
    output logic             valid_o
);

    typedef struct packed {
        logic [CTR_W-1:0] step;
        logic             primed;
        logic             valid;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        load_o   = &s_q.step;
        publish_o = load_o & s_q.primed;
        s_d.step = s_q.step + 1'b1;
        s_d.valid = publish_o;
        if (load_o) begin
            s_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign step_o  = s_q.step;
    assign phase_o = s_q.step[1:0];
    assign valid_o = s_q.valid;

    // R7: strobe lasts a single cycle
    a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R7: strobe coincides with frame cycle 0
    a_r7_valid_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (step_o == '0));

endmodule

// File: rtl/ifpd_iq_extract.sv
`timescale 1ns/1ps
module ifpd_iq_extract #(
    parameter int DATA_W = 16,
    parameter int WORK_W = DATA_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               phase_i,
    input  logic [DATA_W-1:0]        sample_i,
    output logic signed [WORK_W-1:0] i_o,
    output logic signed [WORK_W-1:0] q_o
);

    typedef struct packed {
        logic [WORK_W-1:0] i;
        logic [WORK_W-1:0] q;
    } iq_t;

    iq_t s_d, s_q;
    logic [WORK_W-1:0] ext;

    always_comb begin
        ext = {{(WORK_W-DATA_W){sample_i[DATA_W-1]}}, sample_i};
        s_d = s_q;
        case (phase_i)
            2'd0:    s_d.i = ext;
            2'd1:    s_d.q = ext;
            2'd2:    s_d.i = -ext;
            default: s_d.q = -ext;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign i_o = $signed(s_q.i);
    assign q_o = $signed(s_q.q);

endmodule

// File: rtl/ifpd_cordic_lane.sv
`timescale 1ns/1ps
module ifpd_cordic_lane
    import ifpd_pkg::*;
#(
    parameter int WORK_W = 18,
    parameter int CTR_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CTR_W-1:0]         step_i,
    input  logic                     load_i,
    input  logic                     publish_i,
    input  logic signed [WORK_W-1:0] i_i,
    input  logic signed [WORK_W-1:0] q_i,
    output logic [WORK_W-1:0]        mag_o,
    output logic [ANG_W-1:0]         phase_o
);

    typedef struct packed {
        logic [WORK_W-1:0] x;
        logic [WORK_W-1:0] y;
        logic [ANG_W-1:0]  z;
        logic [WORK_W-1:0] mag;
        logic [ANG_W-1:0]  ph;
    } lane_t;

    lane_t s_d, s_q;
    logic signed [WORK_W-1:0] x_cur, y_cur, x_sh, y_sh;
    logic [ANG_W-1:0] step_ang;

    always_comb begin
        s_d      = s_q;
        x_cur    = $signed(s_q.x);
        y_cur    = $signed(s_q.y);
        x_sh     = x_cur >>> step_i;
        y_sh     = y_cur >>> step_i;
        step_ang = micro_angle(4'(step_i));
        if (load_i) begin
            if (publish_i) begin
                s_d.mag = s_q.x;
                s_d.ph  = s_q.z;
            end
            if (!q_i[WORK_W-1]) begin
                s_d.x = q_i;
                s_d.y = -i_i;
                s_d.z = QUARTER_TURN;
            end else begin
                s_d.x = -q_i;
                s_d.y = i_i;
                s_d.z = -QUARTER_TURN;
            end
        end else if (y_cur[WORK_W-1]) begin
            s_d.x = x_cur - y_sh;
            s_d.y = y_cur + x_sh;
            s_d.z = s_q.z - step_ang;
        end else begin
            s_d.x = x_cur + y_sh;
            s_d.y = y_cur - x_sh;
            s_d.z = s_q.z + step_ang;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mag_o   = s_q.mag;
    assign phase_o = s_q.ph;

    // R8: coarse rotation leaves x non-negative, even for full-scale input
    a_r8_coarse_x_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !s_q.x[WORK_W-1]);

    // R3: micro-rotations never shrink x
    a_r3_x_grows: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($signed(s_q.x) >= $signed($past(s_q.x))));

    // R3: a published magnitude is never negative
    a_r3_mag_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        publish_i |=> !s_q.mag[WORK_W-1]);

endmodule

// File: rtl/if_phase_detector.sv
`timescale 1ns/1ps
module if_phase_detector
    import ifpd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CTR_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DATA_W-1:0]   fwd_sample_i,
    input  logic [DATA_W-1:0]   refl_sample_i,
    input  logic [DATA_W-1:0]   cav_sample_i,
    output logic [DATA_W+1:0]   fwd_mag_o,
    output logic [ANG_W-1:0]    fwd_phase_o,
    output logic [DATA_W+1:0]   refl_mag_o,
    output logic [ANG_W-1:0]    refl_phase_o,
    output logic [DATA_W+1:0]   cav_mag_o,
    output logic [ANG_W-1:0]    cav_phase_o,
    output logic                result_valid_o
);

    localparam int WORK_W = DATA_W + 2;

    logic [CTR_W-1:0] step;
    logic [1:0]       phase;
    logic             load, publish;

    logic [DATA_W-1:0]        samples [NUM_CH];
    logic signed [WORK_W-1:0] i_val   [NUM_CH];
    logic signed [WORK_W-1:0] q_val   [NUM_CH];
    logic [WORK_W-1:0]        mags    [NUM_CH];
    logic [ANG_W-1:0]         phs     [NUM_CH];

    assign samples[0] = fwd_sample_i;
    assign samples[1] = refl_sample_i;
    assign samples[2] = cav_sample_i;

    ifpd_sequencer #(.CTR_W(CTR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_o    (step),
        .phase_o   (phase),
        .load_o    (load),
        .publish_o (publish),
        .valid_o   (result_valid_o)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        ifpd_iq_extract #(.DATA_W(DATA_W), .WORK_W(WORK_W)) u_iq (
            .clk      (clk),
            .rst_n    (rst_n),
            .phase_i  (phase),
            .sample_i (samples[ch]),
            .i_o      (i_val[ch]),
            .q_o      (q_val[ch])
        );

        ifpd_cordic_lane #(.WORK_W(WORK_W), .CTR_W(CTR_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .step_i    (step),
            .load_i    (load),
            .publish_i (publish),
            .i_i       (i_val[ch]),
            .q_i       (q_val[ch]),
            .mag_o     (mags[ch]),
            .phase_o   (phs[ch])
        );
    end

    assign fwd_mag_o    = mags[0];
    assign fwd_phase_o  = phs[0];
    assign refl_mag_o   = mags[1];
    assign refl_phase_o = phs[1];
    assign cav_mag_o    = mags[2];
    assign cav_phase_o  = phs[2];

    // R7 / R6: no output of any channel moves without the shared strobe
    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid_o |-> $stable({fwd_mag_o, fwd_phase_o, refl_mag_o,
                                     refl_phase_o, cav_mag_o, cav_phase_o}));

endmodule

// File: tb/tb_if_phase_detector.sv
`timescale 1ns/1ps
module tb_if_phase_detector;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] smp [3];
    logic [17:0] mags [3];
    logic [15:0] phs [3];
    logic        valid;

    always #2.5 clk = ~clk;

    if_phase_detector dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fwd_sample_i   (smp[0]),
        .refl_sample_i  (smp[1]),
        .cav_sample_i   (smp[2]),
        .fwd_mag_o      (mags[0]),
        .fwd_phase_o    (phs[0]),
        .refl_mag_o     (mags[1]),
        .refl_phase_o   (phs[1]),
        .cav_mag_o      (mags[2]),
        .cav_phase_o    (phs[2]),
        .result_valid_o (valid)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    bit    finished = 1'b0;
    int    exp_q [$];
    string tag_q [$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Driver: pushes one frame's expectation, then drives its 16 samples per channel
    task automatic drive_frame(input int fi[3], input int fq[3], input bit scramble,
                               input string tag);
        for (int ch = 0; ch < 3; ch++) begin
            exp_q.push_back(fi[ch]);
            exp_q.push_back(fq[ch]);
        end
        tag_q.push_back(tag);
        for (int c = 0; c < 16; c++) begin
            for (int ch = 0; ch < 3; ch++) begin
                int v;
                case (c % 4)
                    0: v = fi[ch];
                    1: v = fq[ch];
                    2: v = -fi[ch];
                    default: v = -fq[ch];
                endcase
                if (scramble && c != 13 && c != 14)
                    v = ((c * 7919 + ch * 10473 + 3) % 65536) - 32768;
                smp[ch] = v[15:0];
            end
            @(negedge clk);
        end
    endtask

    task automatic drive_idle(input int n);
        for (int c = 0; c < n; c++) begin
            for (int ch = 0; ch < 3; ch++) smp[ch] = 16'd0;
            @(negedge clk);
        end
    endtask

    // Cycle counter: cycle 0 is the first clock after reset release
    initial begin
        wait (rst_n === 1'b1);
        forever @(posedge clk) cyc++;
    end

    // Monitor / scoreboard
    initial begin
        int          k = 0;
        int          last_valid = 0;
        bit          moved = 1'b0;
        logic [17:0] snap_m [3];
        logic [15:0] snap_p [3];
        for (int ch = 0; ch < 3; ch++) begin
            snap_m[ch] = '0;
            snap_p[ch] = '0;
        end
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            if (valid) begin
                if (exp_q.size() >= 6) begin
                    string tag;
                    tag = tag_q.pop_front();
                    check(cyc == 16 * (k + 2), "R9", "publish cycle", cyc, 16 * (k + 2));
                    if (k > 0) begin
                        check(cyc - last_valid == 16, "R7", "strobe spacing", cyc - last_valid, 16);
                        check(!moved, "R7", "outputs held between strobes", int'(moved), 0);
                    end
                    // R6: all three lanes compared on this single strobe against one frame
                    for (int ch = 0; ch < 3; ch++) begin
                        int  ei, eq, am, ap;
                        real ri, rq, em, ep, d;
                        ei = exp_q.pop_front();
                        eq = exp_q.pop_front();
                        ri = ei;
                        rq = eq;
                        em = 1.64676 * $sqrt(ri * ri + rq * rq);
                        am = int'(mags[ch]);
                        d  = am - em;
                        check((d < 24.0 + 0.001 * em) && (d > -24.0 - 0.001 * em),
                              {tag, "/R3/R6"}, $sformatf("ch%0d magnitude", ch), am, int'(em));
                        ep = $atan2(rq, ri) * 32768.0 / 3.14159265358979;
                        ap = int'($signed(phs[ch]));
                        d  = ap - ep;
                        while (d > 32768.0)  d = d - 65536.0;
                        while (d < -32768.0) d = d + 65536.0;
                        check((d < 40.0) && (d > -40.0),
                              {tag, "/R4/R6"}, $sformatf("ch%0d phase", ch), ap, int'(ep));
                    end
                    k++;
                end
                last_valid = cyc;
                moved = 1'b0;
                for (int ch = 0; ch < 3; ch++) begin
                    snap_m[ch] = mags[ch];
                    snap_p[ch] = phs[ch];
                end
            end else begin
                for (int ch = 0; ch < 3; ch++)
                    if (mags[ch] !== snap_m[ch] || phs[ch] !== snap_p[ch]) moved = 1'b1;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        for (int ch = 0; ch < 3; ch++) smp[ch] = 16'h7abc;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(valid == 1'b0, "R1", "valid in reset", int'(valid), 0);
        for (int ch = 0; ch < 3; ch++) begin
            check(mags[ch] == '0, "R1", $sformatf("ch%0d magnitude in reset", ch), int'(mags[ch]), 0);
            check(phs[ch] == '0, "R1", $sformatf("ch%0d phase in reset", ch), int'(phs[ch]), 0);
        end
        rst_n = 1'b1;
        // R5: on-axis vectors
        drive_frame('{8000, 0, -8000}, '{0, 8000, 0}, 1'b0, "R5");
        // R1: still quiet during the first frames (first strobe in cycle 32)
        check(valid == 1'b0 && mags[0] == '0, "R1", "no output before first publish",
              int'(valid), 0);
        drive_frame('{0, 5000, -6000}, '{-8000, 5000, 6000}, 1'b0, "R5");
        // R4: general quadrants
        drive_frame('{12000, -7000, 3000}, '{5000, -9000, -20000}, 1'b0, "R4");
        // R8: full-scale corner (I = +32768 comes from a -32768 sample in cycle 14)
        drive_frame('{32768, -32767, 32767}, '{-32768, 32767, 32767}, 1'b0, "R8");
        // R2: only cycles 13 and 14 matter; the rest carry scrambled values
        drive_frame('{3000, -2000, 25000}, '{-4000, 1500, -100}, 1'b1, "R2");
        // R6: three unrelated vectors in one frame
        drive_frame('{1200, -30000, 4096}, '{-900, 10000, 4096}, 1'b0, "R6");
        drive_frame('{-100, 15000, -20000}, '{-20000, -15000, -1}, 1'b0, "R3");
        drive_idle(48);
        check(exp_q.size() == 0, "R9", "all frames published", exp_q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule